// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the external bus timing of a small 8-bit processor. The processor has a 16-bit address space and a low address byte that shares its pins with the data byte. The core hands over one request at a time: a cycle kind, an address and, for writes, a data byte. The sequencer then walks through the T-states of that machine cycle, one per clock. As it goes it drives the address strobe, the memory/I-O select, a two-bit status code, active-low read and write strobes, the upper address byte and the shared byte lanes. For reads it returns the byte that was on the shared lanes. A pulse marks the last T-state of every cycle.

A slow device stretches a cycle by holding the ready input low. A second bus master asks for the bus with a hold request. The sequencer finishes the cycle in progress and starts no new one. It then releases the bus pins through their output enables and acknowledges. When the request goes away, it takes the bus back one cycle later.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the strobe, the done pulse and the hold acknowledge are low, both active-low strobes are high, the shared lanes are not driven, the address/control pins are driven and a request is accepted.
- R2: In the first T-state of every cycle the address strobe is high for exactly one clock. The shared lanes carry the low address byte with their enable high, and `addr_hi` carries the upper byte.
- R3: Request kind codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. An opcode fetch lasts four T-states and every other kind lasts three, each without wait states. `done` is high during the last T-state only.
- R4: While a cycle runs, `io_sel` is 1 for the two I/O kinds and 0 otherwise. `st_code` (bit 1 first) is 11 for a fetch, 10 for either read and 01 for either write. Outside a cycle it is 00.
- R5: In read and fetch cycles the read strobe is low from the second T-state through the third, including wait states. The shared lanes are released during that window and the write strobe stays high.
- R6: In write cycles the write strobe is low from the second T-state through the third. The shared lanes drive the write byte in that window and the read strobe stays high.
- R7: `bus_ready` is sampled at the end of the second T-state and of every wait state. Each low sample adds one wait state before the third T-state.
- R8: For read and fetch cycles `rd_data` takes the shared-lane input at the end of the third T-state and holds it until the next read.
- R9: In I/O cycles the low 8 bits of the request address appear on both the shared lanes and `addr_hi`.
- R10: A hold request lets the running cycle finish with its normal length. No new cycle starts while the hold is in effect, even with a request pending.
- R11: While `hold_ack` is high, both `bus_oe` and `ad_oe` are low.
- R12: `hold_ack` falls one clock after the hold request is withdrawn. A pending request then starts on the following clock.
- R13: A request present during the last T-state of a cycle starts its first T-state on the very next clock, with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | a request is presented |
| req_type | input | 3 | cycle kind code |
| req_addr | input | 16 | cycle address |
| req_wdata | input | 8 | byte to write |
| req_take | output | 1 | request is accepted at this clock edge if valid |
| bus_ready | input | 1 | device ready, low inserts wait states |
| hold_req | input | 1 | other master wants the bus |
| hold_ack | output | 1 | bus released to the other master |
| addr_strobe | output | 1 | low address byte present on shared lanes |
| st_code | output | 2 | cycle status code |
| io_sel | output | 1 | 1 for I/O cycles, 0 for memory |
| bus_rd_n | output | 1 | active-low read strobe |
| bus_wr_n | output | 1 | active-low write strobe |
| bus_oe | output | 1 | enable for addr_hi, strobes and io_sel |
| addr_hi | output | 8 | upper address byte |
| ad_out | output | 8 | byte driven on the shared lanes |
| ad_oe | output | 1 | enable for the shared lanes |
| ad_in | input | 8 | byte read from the shared lanes |
| rd_data | output | 8 | captured read byte |
| done | output | 1 | last T-state of a cycle |

## Verification
The hardest situation to reach is a hold request that arrives in the middle of a read cycle while a new request is already waiting. In that case the cycle end, the hold entry, the bus release and the restart all fall on neighbouring clocks. The stimulus starts a memory read and, in its second T-state, raises both the hold request and the next request. It then checks that the read completes and its data is kept, that no strobe appears during the hold, and that the waiting I/O write starts exactly two clocks after the hold is dropped. Wait states are counted by keeping `bus_ready` low for a chosen number of sampling edges and checking the length of the strobe window.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_TW, PH_T3, PH_T4, PH_HOLD
  } phase_e;

  localparam logic [2:0] CY_FETCH = 3'd0;
  localparam logic [2:0] CY_MRD   = 3'd1;
  localparam logic [2:0] CY_MWR   = 3'd2;
  localparam logic [2:0] CY_IORD  = 3'd3;
  localparam logic [2:0] CY_IOWR  = 3'd4;

  function automatic logic cy_is_write(input logic [2:0] t);
    return (t == CY_MWR) || (t == CY_IOWR);
  endfunction

  function automatic logic cy_is_io(input logic [2:0] t);
    return (t == CY_IORD) || (t == CY_IOWR);
  endfunction

  function automatic logic [1:0] cy_status(input logic [2:0] t);
    case (t)
      CY_FETCH:        return 2'b11;
      CY_MWR, CY_IOWR: return 2'b01;
      default:         return 2'b10;
    endcase
  endfunction

  function automatic logic ph_data(input phase_e p);
    return (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
  endfunction

  function automatic logic ph_cycle(input phase_e p);
    return (p != PH_IDLE) && (p != PH_HOLD);
  endfunction

endpackage

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_type,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          bus_ready,
  input  logic          hold_req,
  output logic          req_take,
  output phase_e        phase_q,
  output phase_e        phase_nx,
  output logic [2:0]    typ_q,
  output logic [2:0]    typ_nx,
  output logic [AW-1:0] addr_nx,
  output logic [DW-1:0] wdata_nx
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          at_end;
  logic          accept;

  assign at_end   = (phase_q == PH_IDLE) || (phase_q == PH_T4) ||
                    ((phase_q == PH_T3) && (typ_q != CY_FETCH));
  assign req_take = at_end && !hold_req;
  assign accept   = req_take && req_valid;

  assign typ_nx   = accept ? req_type  : typ_q;
  assign addr_nx  = accept ? req_addr  : addr_q;
  assign wdata_nx = accept ? req_wdata : wdata_q;

  always_comb begin
    phase_nx = phase_q;
    case (phase_q)
      PH_T1:        phase_nx = PH_T2;
      PH_T2, PH_TW: phase_nx = bus_ready ? PH_T3 : PH_TW;
      PH_HOLD:      phase_nx = hold_req ? PH_HOLD : PH_IDLE;
      default: ;
    endcase
    if (phase_q == PH_T3 && typ_q == CY_FETCH)
      phase_nx = PH_T4;
    else if (at_end)
      phase_nx = accept ? PH_T1 : (hold_req ? PH_HOLD : PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      typ_q   <= CY_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      phase_q <= phase_nx;
      typ_q   <= typ_nx;
      addr_q  <= addr_nx;
      wdata_q <= wdata_nx;
    end
  end

  // R7: a low ready sample in T2 yields a wait state
  p_wait_entry_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_T2 && !bus_ready) |=> (phase_q == PH_TW));

  // R10: the hold phase is entered only from a cycle boundary
  p_hold_boundary_r10: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HOLD && $past(phase_q) != PH_HOLD) |->
      ($past(phase_q) == PH_IDLE || $past(phase_q) == PH_T3 ||
       $past(phase_q) == PH_T4));

endmodule

// File: rtl/busseq_rdcap.sv
module busseq_rdcap
  import busseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        phase_q,
  input  logic [2:0]    typ_q,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rd_data
);

  logic grab;
  assign grab = (phase_q == PH_T3) && !cy_is_write(typ_q);

  always_ff @(posedge clk) begin
    if (rst)       rd_data <= '0;
    else if (grab) rd_data <= ad_in;
  end

  // R8: the captured byte changes only at the end of a read T3
  p_cap_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !grab |=> $stable(rd_data));

endmodule

// File: rtl/busseq_pins.sv
module busseq_pins
  import busseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_e           phase_nx,
  input  logic [2:0]       typ_nx,
  input  logic [AW-1:0]    addr_nx,
  input  logic [DW-1:0]    wdata_nx,
  output logic             hold_ack,
  output logic             addr_strobe,
  output logic [1:0]       st_code,
  output logic             io_sel,
  output logic             bus_rd_n,
  output logic             bus_wr_n,
  output logic             bus_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic             done
);

  localparam int HW = AW - DW;

  logic          wr_k;
  logic          io_k;
  logic          in_cyc;
  logic          in_data;
  logic [HW-1:0] hi_nx;

  assign wr_k    = cy_is_write(typ_nx);
  assign io_k    = cy_is_io(typ_nx);
  assign in_cyc  = ph_cycle(phase_nx);
  assign in_data = ph_data(phase_nx);
  assign hi_nx   = io_k ? HW'(addr_nx[DW-1:0]) : addr_nx[AW-1:DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_ack    <= 1'b0;
      addr_strobe <= 1'b0;
      st_code     <= 2'b00;
      io_sel      <= 1'b0;
      bus_rd_n    <= 1'b1;
      bus_wr_n    <= 1'b1;
      bus_oe      <= 1'b1;
      addr_hi     <= '0;
      ad_out      <= '0;
      ad_oe       <= 1'b0;
      done        <= 1'b0;
    end else begin
      hold_ack    <= (phase_nx == PH_HOLD);
      bus_oe      <= (phase_nx != PH_HOLD);
      addr_strobe <= (phase_nx == PH_T1);
      st_code     <= in_cyc ? cy_status(typ_nx) : 2'b00;
      io_sel      <= in_cyc && io_k;
      bus_rd_n    <= !(in_data && !wr_k);
      bus_wr_n    <= !(in_data && wr_k);
      addr_hi     <= hi_nx;
      ad_out      <= (phase_nx == PH_T1) ? addr_nx[DW-1:0] : wdata_nx;
      ad_oe       <= (phase_nx == PH_T1) || (in_data && wr_k);
      done        <= ((phase_nx == PH_T3) && (typ_nx != CY_FETCH)) ||
                     (phase_nx == PH_T4);
    end
  end

  // R5/R6: never both strobes at once
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));

  // R2: the address strobe lasts a single clock
  p_strobe_once_r2: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |=> !addr_strobe);

  // R11: bus released during hold
  p_float_r11: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!ad_oe && !bus_oe));

  // R3: done is a one-clock pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import busseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_type,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_take,
  input  logic             bus_ready,
  input  logic             hold_req,
  output logic             hold_ack,
  output logic             addr_strobe,
  output logic [1:0]       st_code,
  output logic             io_sel,
  output logic             bus_rd_n,
  output logic             bus_wr_n,
  output logic             bus_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    rd_data,
  output logic             done
);

  phase_e        phase_q;
  phase_e        phase_nx;
  logic [2:0]    typ_q;
  logic [2:0]    typ_nx;
  logic [AW-1:0] addr_nx;
  logic [DW-1:0] wdata_nx;

  busseq_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_ready(bus_ready),
    .hold_req(hold_req), .req_take(req_take), .phase_q(phase_q),
    .phase_nx(phase_nx), .typ_q(typ_q), .typ_nx(typ_nx),
    .addr_nx(addr_nx), .wdata_nx(wdata_nx)
  );

  busseq_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst), .phase_nx(phase_nx), .typ_nx(typ_nx),
    .addr_nx(addr_nx), .wdata_nx(wdata_nx), .hold_ack(hold_ack),
    .addr_strobe(addr_strobe), .st_code(st_code), .io_sel(io_sel),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_oe(bus_oe),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .done(done)
  );

  busseq_rdcap #(.DW(DW)) u_rdcap (
    .clk(clk), .rst(rst), .phase_q(phase_q), .typ_q(typ_q),
    .ad_in(ad_in), .rd_data(rd_data)
  );

endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_type = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0;
  logic       req_take;
  logic       bus_ready = 1'b1;
  logic       hold_req = 1'b0;
  logic       hold_ack, addr_strobe, io_sel, bus_rd_n, bus_wr_n, bus_oe, ad_oe, done;
  logic [1:0] st_code;
  logic [7:0] addr_hi, ad_out, rd_data;
  logic [7:0] ad_in = 8'h0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_take(req_take),
    .bus_ready(bus_ready), .hold_req(hold_req), .hold_ack(hold_ack),
    .addr_strobe(addr_strobe), .st_code(st_code), .io_sel(io_sel),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_oe(bus_oe),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_st(input logic [2:0] t);
    case (t)
      3'd0: return 2'b11;
      3'd2, 3'd4: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  // packed pins: strobe, ad_oe, rd_n, wr_n, done, st_code, io_sel
  function automatic logic [7:0] pins();
    return {addr_strobe, ad_oe, bus_rd_n, bus_wr_n, done, st_code, io_sel};
  endfunction

  task automatic run_cycle(input logic [2:0] t, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rv, input int w);
    bit wr = (t == 3'd2) || (t == 3'd4);
    bit io = (t == 3'd3) || (t == 3'd4);
    int len = 3 + w + ((t == 3'd0) ? 1 : 0);
    logic [7:0] hi = io ? a[7:0] : a[15:8];
    @(negedge clk);
    chk(req_take == 1'b1, "R1 take-when-idle", req_take, 1);
    req_valid = 1; req_type = t; req_addr = a; req_wdata = wd; ad_in = rv;
    bus_ready = 1;
    @(negedge clk);
    req_valid = 0;
    for (int k = 1; k <= len; k++) begin
      bit act = (k >= 2) && (k <= 3 + w);
      logic [7:0] e;
      string tag;
      bus_ready = !((k >= 2) && (k <= 1 + w));
      e = {k == 1, (k == 1) || (act && wr), !(act && !wr), !(act && wr),
           k == len, exp_st(t), io};
      if (k == 1) tag = "R2 R4 T1 pins";
      else if (k > 2 && k <= 2 + w) tag = "R7 wait-state pins";
      else if (k == len) tag = "R3 last-state pins";
      else if (wr) tag = "R6 write strobe";
      else tag = "R5 read strobe";
      chk(pins() == e, tag, pins(), e);
      if (k == 1) begin
        chk(ad_out == a[7:0], io ? "R9 low port byte" : "R2 low addr", ad_out, a[7:0]);
        chk(addr_hi == hi, io ? "R9 port on upper byte" : "R2 upper addr", addr_hi, hi);
      end
      if (act && wr)
        chk(ad_out == wd, "R6 write byte", ad_out, wd);
      @(negedge clk);
    end
    bus_ready = 1;
    chk(done == 1'b0 && addr_strobe == 1'b0, "R3 cycle ended", {done, addr_strobe}, 0);
    if (!wr)
      chk(rd_data == rv, "R8 read byte", rd_data, rv);
  endtask

  task automatic t_reset();
    chk({addr_strobe, done, hold_ack, bus_rd_n, bus_wr_n, ad_oe, bus_oe} == 7'b0001101,
        "R1 reset pins", {addr_strobe, done, hold_ack, bus_rd_n, bus_wr_n, ad_oe, bus_oe}, 7'b0001101);
  endtask

  task automatic t_plain();
    run_cycle(3'd0, 16'h1A2B, 8'h00, 8'h3C, 0);
    run_cycle(3'd1, 16'hC200, 8'h00, 8'h5A, 0);
    run_cycle(3'd2, 16'h8001, 8'hA7, 8'h00, 0);
    run_cycle(3'd3, 16'hFF80, 8'h00, 8'h39, 0);
    run_cycle(3'd4, 16'h0042, 8'h91, 8'h00, 0);
  endtask

  task automatic t_waits();
    run_cycle(3'd1, 16'h2345, 8'h00, 8'hE1, 2);
    run_cycle(3'd2, 16'h6789, 8'h4D, 8'h00, 1);
    run_cycle(3'd0, 16'h0100, 8'h00, 8'h76, 1);
  endtask

  task automatic t_back2back();
    @(negedge clk);
    req_valid = 1; req_type = 3'd1; req_addr = 16'h1111; ad_in = 8'h22;
    @(negedge clk); // T1 of first
    req_type = 3'd2; req_addr = 16'h3344; req_wdata = 8'h55;
    @(negedge clk); // T2
    @(negedge clk); // T3
    chk(done == 1'b1, "R13 first done", done, 1);
    @(negedge clk); // must be T1 of second
    req_valid = 0;
    chk(addr_strobe == 1'b1, "R13 no idle gap", addr_strobe, 1);
    chk(addr_hi == 8'h33 && ad_out == 8'h44, "R13 second address", {addr_hi, ad_out}, 16'h3344);
    chk(rd_data == 8'h22, "R8 read byte before next", rd_data, 8'h22);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_hold_mid();
    @(negedge clk);
    req_valid = 1; req_type = 3'd1; req_addr = 16'h4455; ad_in = 8'hC3;
    @(negedge clk); // T1
    req_valid = 0;
    @(negedge clk); // T2
    hold_req = 1;
    req_valid = 1; req_type = 3'd4; req_addr = 16'h0077; req_wdata = 8'h0F;
    @(negedge clk); // T3 of running read
    chk(done == 1'b1 && hold_ack == 1'b0 && bus_rd_n == 1'b0, "R10 cycle finishes",
        {done, hold_ack, bus_rd_n}, 3'b100);
    @(negedge clk);
    chk(hold_ack == 1'b1, "R10 ack after cycle", hold_ack, 1);
    chk(bus_oe == 1'b0 && ad_oe == 1'b0, "R11 pins released", {bus_oe, ad_oe}, 0);
    chk(rd_data == 8'hC3, "R8 read kept across hold", rd_data, 8'hC3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(addr_strobe == 1'b0 && hold_ack == 1'b1, "R10 no new cycle in hold",
          {addr_strobe, hold_ack}, 2'b01);
    end
    hold_req = 0;
    @(negedge clk);
    chk(hold_ack == 1'b0 && addr_strobe == 1'b0, "R12 ack falls", {hold_ack, addr_strobe}, 0);
    @(negedge clk);
    req_valid = 0;
    chk(addr_strobe == 1'b1 && addr_hi == 8'h77 && bus_oe == 1'b1, "R12 pending starts",
        {addr_strobe, addr_hi, bus_oe}, {1'b1, 8'h77, 1'b1});
    repeat (3) @(negedge clk);
  endtask

  task automatic t_hold_idle();
    @(negedge clk);
    hold_req = 1;
    @(negedge clk);
    chk(hold_ack == 1'b1 && req_take == 1'b0, "R10 idle hold", {hold_ack, req_take}, 2'b10);
    chk(bus_oe == 1'b0 && ad_oe == 1'b0, "R11 idle release", {bus_oe, ad_oe}, 0);
    hold_req = 0;
    @(negedge clk);
    chk(hold_ack == 1'b0 && bus_oe == 1'b1, "R12 idle resume", {hold_ack, bus_oe}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_waits();
    t_back2back();
    t_hold_mid();
    t_hold_idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule